// File: doc/BRIEF.md
# Multinodeword Slot Packer

This block sits between an instruction decoder and a node-table issue stage. It accepts decoded nodes one per cycle, in program order. Each node carries a type (memory or ALU), an opaque operation code, an optional destination register and two source operands. It groups the nodes of one atomic unit into multinodewords. Each multinodeword has one memory slot and three ALU slots. Once the unit is closed, the words are released on a valid/ready output stream, oldest first.

The unit boundary is chosen by a mode input. With `mode_bb` low, every instruction is its own unit, so a new instruction always starts a fresh word. With `mode_bb` high, consecutive instructions of one basic block share words until the block-end flag. Within a unit the block does two rewrites. A source operand that names an earlier node of the same unit, by its ordinal in arrival order, is rewritten to that node's packed position. A register write that a later node of the same unit overwrites is disabled, so that only the final write to each register survives. The producer guarantees three things: a unit fits in `MAX_WORDS` words, an in-unit value is always read through a local reference, and `mode_bb` only changes between units.

Top module: `mnw_packer`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A memory node occupies slot 0 of a word, and ALU nodes fill slots 1, 2, 3 in arrival order. A word holds at most one memory node and three ALU nodes, and a memory node never goes into a word below that of an earlier memory node.
- R3: With `mode_bb`=0 a unit closes at every node with `in_instr_end`=1. Two memory nodes of one instruction, followed by six ALU nodes of the next, give four words.
- R4: With `mode_bb`=1 a unit closes only at `in_block_end`=1. The same eight nodes give two words: memory ops in slot 0 of words 0 and 1, and ALU ops in slots 1–3 of both.
- R5: Each slot has a valid bit. Slots left unused when a unit closes are output with the valid bit at 0.
- R6: When a later node of the same unit writes the same register, the earlier node's `dst_en` is 0 on output. Writes in different units are all kept.
- R7: A source with `loc`=1 and ordinal k is output with `loc`=1 and value word*4+slot of node k of the unit. A source with `loc`=0 passes its register number unchanged.
- R8: A node is never placed in a word below the word of a node it references locally. An ALU node whose producer lies in a later word than the ALU fill point moves to slot 1 of the producer's word. The ALU slots it skips stay empty, and later ALU nodes continue after it.
- R9: While words are pending, `in_ready` is 0. While `out_valid`=1 and `out_ready`=0, `out_word` and `out_last` hold steady.
- R10: Words of a unit leave in ascending word order, and `out_last`=1 marks exactly the final word of each unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_bb | input | 1 | 0: instruction units, 1: basic-block units |
| in_valid | input | 1 | Node present |
| in_ready | output | 1 | Node accepted when valid |
| in_is_mem | input | 1 | 1: memory node, 0: ALU node |
| in_op | input | OP_W (8) | Operation code, carried through |
| in_dst_en | input | 1 | Node writes a register |
| in_dst | input | REG_W (4) | Destination register |
| in_srca_loc | input | 1 | Source A is an in-unit ordinal |
| in_srca_val | input | SRCV_W (5) | Source A register or ordinal |
| in_srcb_loc | input | 1 | Source B is an in-unit ordinal |
| in_srcb_val | input | SRCV_W (5) | Source B register or ordinal |
| in_instr_end | input | 1 | Last node of an instruction |
| in_block_end | input | 1 | Last node of a basic block |
| out_valid | output | 1 | Word present |
| out_ready | input | 1 | Word taken when valid |
| out_word | output | 104 | Four slots, slot 0 in the low bits, each {vld, op, dst_en, dst, srcB, srcA} |
| out_last | output | 1 | Final word of the unit |

## Verification
A wrong fill pointer shows up in the first word of the unit: a node appears in the wrong slot, or the unit has the wrong word count. An error in the last-writer table or the ordinal table is only visible when the unit drains. It shows as a `dst_en` bit or a rewritten source value on a word that may leave several cycles after the faulty node went in. Each scenario therefore checks every slot of every word it produces. A stuck drain index or a bad unit-close decision shows as a missing or extra `out_last`, or as `in_ready` staying low.

// File: rtl/mnw_pkg.sv
package mnw_pkg;
    parameter int OP_W      = 8;
    parameter int REG_W     = 4;
    parameter int MAX_WORDS = 8;   // power of two
    parameter int ALU_SLOTS = 3;
    parameter int NSRC      = 2;

    localparam int SLOTS     = ALU_SLOTS + 1;
    localparam int NREGS     = 1 << REG_W;
    localparam int WORD_W    = $clog2(MAX_WORDS);
    localparam int PTR_W     = WORD_W + 1;
    localparam int SLOT_W    = $clog2(SLOTS);
    localparam int MAX_NODES = MAX_WORDS * SLOTS;
    localparam int ORD_W     = $clog2(MAX_NODES);
    localparam int POS_W     = WORD_W + SLOT_W;
    localparam int SRCV_W    = (POS_W > REG_W) ? POS_W : REG_W;

    typedef struct packed {
        logic              loc;
        logic [SRCV_W-1:0] val;
    } src_t;

    typedef struct packed {
        logic             vld;
        logic [OP_W-1:0]  op;
        logic             dst_en;
        logic [REG_W-1:0] dst;
        src_t [NSRC-1:0]  src;
    } slot_t;

    typedef slot_t [SLOTS-1:0] word_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [SLOT_W-1:0] slot;
    } pos_t;
endpackage

// File: rtl/mnw_slot_alloc.sv
// Slot allocator: picks the word and slot for the next node of a unit.
// The memory and ALU streams have separate fill points. A node is never
// placed below the word given on dep_word.
// Assumes the caller keeps a unit within MAX_WORDS words.
module mnw_slot_alloc
    import mnw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              place_en,
    input  logic              is_mem,
    input  logic [PTR_W-1:0]  dep_word,
    output logic [PTR_W-1:0]  place_word,
    output logic [SLOT_W-1:0] place_slot,
    output logic [PTR_W-1:0]  used_words
);
    logic [PTR_W-1:0]  mem_next;
    logic [PTR_W-1:0]  alu_word;
    logic [SLOT_W-1:0] alu_idx;
    logic [SLOT_W-1:0] alu_pick;
    logic [PTR_W-1:0]  word_after;

    // Placement: the later of the fill point and the dependency word.
    always_comb begin
        alu_pick = '0;
        if (is_mem) begin
            place_word = (dep_word > mem_next) ? dep_word : mem_next;
            place_slot = '0;
        end else begin
            if (dep_word > alu_word) begin
                place_word = dep_word;
                alu_pick   = '0;
            end else begin
                place_word = alu_word;
                alu_pick   = alu_idx;
            end
            place_slot = alu_pick + SLOT_W'(1);
        end
        word_after = place_word + PTR_W'(1);
    end

    // Fill points and used-word count advance on each placement.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            mem_next   <= '0;
            alu_word   <= '0;
            alu_idx    <= '0;
            used_words <= '0;
        end else if (place_en) begin
            if (is_mem) begin
                mem_next <= word_after;
            end else if (alu_pick == SLOT_W'(ALU_SLOTS - 1)) begin
                alu_word <= word_after;
                alu_idx  <= '0;
            end else begin
                alu_word <= place_word;
                alu_idx  <= alu_pick + SLOT_W'(1);
            end
            if (word_after > used_words) used_words <= word_after;
        end
    end

    // R2: a memory placement never lands below the previous memory word.
    p_mem_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        place_en && is_mem && !clear |=> (mem_next > $past(place_word)));
endmodule

// File: rtl/mnw_writer_track.sv
// Last-writer table: records, per register, the packed position of the
// newest write in the current unit. It flags the older write for removal
// when a later node writes the same register.
module mnw_writer_track
    import mnw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_reg,
    input  pos_t             wr_pos,
    output logic             kill_en,
    output pos_t             kill_pos
);
    logic [NREGS-1:0] tab_vld;
    pos_t             tab_pos [NREGS];

    // Older writer lookup for the incoming register.
    always_comb begin
        kill_en  = wr_en && tab_vld[wr_reg];
        kill_pos = tab_pos[wr_reg];
    end

    // Table update: the newest writer replaces any older one.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            tab_vld <= '0;
            for (int r = 0; r < NREGS; r++) tab_pos[r] <= '0;
        end else if (wr_en) begin
            tab_vld[wr_reg] <= 1'b1;
            tab_pos[wr_reg] <= wr_pos;
        end
    end

    // R6: the write being removed is never the one being placed.
    p_kill_older_r6: assert property (@(posedge clk) disable iff (!rst_n)
        kill_en |-> (kill_pos != wr_pos));
endmodule

// File: rtl/mnw_word_store.sv
// Word store: holds the multinodewords of one unit while it fills. It has
// one slot write port, one dst_en clear port and one combinational word
// read port. A clear empties every slot.
module mnw_word_store
    import mnw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  pos_t              wr_pos,
    input  slot_t             wr_slot,
    input  logic              kill_en,
    input  pos_t              kill_pos,
    input  logic [WORD_W-1:0] rd_word,
    output word_t             rd_data
);
    word_t mem_q [MAX_WORDS];

    // Read port for the drain side.
    always_comb rd_data = mem_q[rd_word];

    // Slot writes and removal of overwritten register writes.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            for (int w = 0; w < MAX_WORDS; w++) mem_q[w] <= '0;
        end else begin
            if (wr_en)   mem_q[wr_pos.word][wr_pos.slot] <= wr_slot;
            if (kill_en) mem_q[kill_pos.word][kill_pos.slot].dst_en <= 1'b0;
        end
    end

    // R2: the allocator never hands out a slot that is already taken.
    p_slot_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !mem_q[wr_pos.word][wr_pos.slot].vld);
    // R6: a removal targets a filled slot that still writes.
    p_kill_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        kill_en |-> (mem_q[kill_pos.word][kill_pos.slot].vld &&
                     mem_q[kill_pos.word][kill_pos.slot].dst_en));
endmodule

// File: rtl/mnw_packer.sv
// Multinodeword packer top. It fills one atomic unit into the word store,
// rewriting local references and removing overwritten writes, then drains
// the unit's words on a valid/ready stream. Input is blocked during drain.
// Assumes units fit in MAX_WORDS words and mode_bb changes only between units.
module mnw_packer
    import mnw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_bb,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic                  in_is_mem,
    input  logic [OP_W-1:0]       in_op,
    input  logic                  in_dst_en,
    input  logic [REG_W-1:0]      in_dst,
    input  logic                  in_srca_loc,
    input  logic [SRCV_W-1:0]     in_srca_val,
    input  logic                  in_srcb_loc,
    input  logic [SRCV_W-1:0]     in_srcb_val,
    input  logic                  in_instr_end,
    input  logic                  in_block_end,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [$bits(word_t)-1:0] out_word,
    output logic                  out_last
);
    typedef enum logic { ST_FILL, ST_DRAIN } state_e;

    state_e            state;
    logic              accept, unit_end, clear;
    logic [ORD_W-1:0]  ord_q;
    pos_t              ord_pos [MAX_NODES];
    logic [NSRC-1:0]   src_loc;
    logic [SRCV_W-1:0] src_val [NSRC];
    src_t [NSRC-1:0]   src_out;
    logic [PTR_W-1:0]  dep_word;
    logic [PTR_W-1:0]  place_word, used_words;
    logic [SLOT_W-1:0] place_slot;
    pos_t              place_pos;
    slot_t             new_slot;
    logic              kill_en;
    pos_t              kill_pos;
    logic [PTR_W-1:0]  rd_idx;
    word_t             rd_data;

    // Handshake and unit-close decision.
    always_comb begin
        in_ready  = (state == ST_FILL);
        out_valid = (state == ST_DRAIN);
        accept    = in_valid && in_ready;
        unit_end  = mode_bb ? in_block_end : (in_instr_end || in_block_end);
        out_last  = out_valid && ((rd_idx + PTR_W'(1)) == used_words);
        clear     = out_valid && out_ready && out_last;
    end

    // Gather both source operands into arrays.
    always_comb begin
        src_loc    = {in_srcb_loc, in_srca_loc};
        src_val[0] = in_srca_val;
        src_val[1] = in_srcb_val;
    end

    // Per-source rewrite and dependency word.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        pos_t ref_pos;
        always_comb begin
            ref_pos        = ord_pos[src_val[i][ORD_W-1:0]];
            src_out[i].loc = src_loc[i];
            src_out[i].val = src_loc[i] ? SRCV_W'(ref_pos) : src_val[i];
        end
    end

    // Latest word among the locally referenced producers.
    always_comb begin
        dep_word = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (src_loc[i] &&
                PTR_W'(ord_pos[src_val[i][ORD_W-1:0]].word) > dep_word)
                dep_word = PTR_W'(ord_pos[src_val[i][ORD_W-1:0]].word);
        end
    end

    mnw_slot_alloc u_alloc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .place_en   (accept),
        .is_mem     (in_is_mem),
        .dep_word   (dep_word),
        .place_word (place_word),
        .place_slot (place_slot),
        .used_words (used_words)
    );

    // Slot image of the incoming node.
    always_comb begin
        place_pos.word  = place_word[WORD_W-1:0];
        place_pos.slot  = place_slot;
        new_slot.vld    = 1'b1;
        new_slot.op     = in_op;
        new_slot.dst_en = in_dst_en;
        new_slot.dst    = in_dst;
        new_slot.src    = src_out;
    end

    mnw_writer_track u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .wr_en    (accept && in_dst_en),
        .wr_reg   (in_dst),
        .wr_pos   (place_pos),
        .kill_en  (kill_en),
        .kill_pos (kill_pos)
    );

    mnw_word_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .wr_en    (accept),
        .wr_pos   (place_pos),
        .wr_slot  (new_slot),
        .kill_en  (kill_en),
        .kill_pos (kill_pos),
        .rd_word  (rd_idx[WORD_W-1:0]),
        .rd_data  (rd_data)
    );

    always_comb out_word = rd_data;

    // Ordinal-to-position table for local reference rewriting.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ord_q <= '0;
            for (int n = 0; n < MAX_NODES; n++) ord_pos[n] <= '0;
        end else if (accept) begin
            ord_pos[ord_q] <= place_pos;
            ord_q          <= ord_q + ORD_W'(1);
        end
    end

    // Fill/drain sequencing and drain index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_FILL;
            rd_idx <= '0;
        end else if (state == ST_FILL) begin
            if (accept && unit_end) state <= ST_DRAIN;
        end else if (out_ready) begin
            if (out_last) begin
                state  <= ST_FILL;
                rd_idx <= '0;
            end else begin
                rd_idx <= rd_idx + PTR_W'(1);
            end
        end
    end

    // R1: reset leaves the block empty and accepting.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && in_ready));
    // R9: no input is taken while words are pending.
    p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
    // R9: a refused word stays put.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_last));
    // R10: a non-final word is followed by another word.
    p_more_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !out_last |=> out_valid);
    // R10: the final word returns the block to filling.
    p_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> !out_valid && in_ready);
    // R8: placement never goes below a referenced producer, and fits.
    p_dep_fit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (place_word >= dep_word) && (place_word < PTR_W'(MAX_WORDS)));
endmodule

// File: tb/tb_mnw_packer.sv
module tb_mnw_packer;
    import mnw_pkg::*;
    localparam int WB = $bits(word_t);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_bb = 1'b0;
    logic in_valid = 1'b0, in_ready, in_is_mem = 1'b0;
    logic [OP_W-1:0] in_op = '0;
    logic in_dst_en = 1'b0;
    logic [REG_W-1:0] in_dst = '0;
    logic in_srca_loc = 1'b0, in_srcb_loc = 1'b0;
    logic [SRCV_W-1:0] in_srca_val = '0, in_srcb_val = '0;
    logic in_instr_end = 1'b0, in_block_end = 1'b0;
    logic out_valid, out_ready = 1'b1, out_last;
    logic [WB-1:0] out_word;

    int n_chk = 0, n_bad = 0;
    logic [WB-1:0] cap [64];
    bit cap_last [64];
    int cap_n = 0;

    always #4 clk = ~clk;   // 125 MHz

    mnw_packer dut (
        .clk(clk), .rst_n(rst_n), .mode_bb(mode_bb),
        .in_valid(in_valid), .in_ready(in_ready), .in_is_mem(in_is_mem),
        .in_op(in_op), .in_dst_en(in_dst_en), .in_dst(in_dst),
        .in_srca_loc(in_srca_loc), .in_srca_val(in_srca_val),
        .in_srcb_loc(in_srcb_loc), .in_srcb_val(in_srcb_val),
        .in_instr_end(in_instr_end), .in_block_end(in_block_end),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_word(out_word), .out_last(out_last)
    );

    // Output monitor, sampling away from the active edge.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready && cap_n < 64) begin
            cap[cap_n] = out_word;
            cap_last[cap_n] = out_last;
            cap_n++;
        end
    end

    task automatic chk(input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Inputs change at posedge+2.
    task automatic send(input bit m, input int op, input bit de, input int dst,
                        input bit al, input int av, input bit bl, input int bv,
                        input bit ie, input bit be);
        while (!in_ready) begin @(posedge clk); #2; end
        in_valid = 1'b1; in_is_mem = m; in_op = OP_W'(op);
        in_dst_en = de; in_dst = REG_W'(dst);
        in_srca_loc = al; in_srca_val = SRCV_W'(av);
        in_srcb_loc = bl; in_srcb_val = SRCV_W'(bv);
        in_instr_end = ie; in_block_end = be;
        @(posedge clk); #2;
        in_valid = 1'b0; in_instr_end = 1'b0; in_block_end = 1'b0;
    endtask

    task automatic alu(input int op, input bit ie, input bit be);
        send(1'b0, op, 1'b0, 0, 1'b0, 0, 1'b0, 0, ie, be);
    endtask

    task automatic mem(input int op, input bit ie, input bit be);
        send(1'b1, op, 1'b0, 0, 1'b0, 0, 1'b0, 0, ie, be);
    endtask

    // Wait for the drain to finish, then check the word count.
    task automatic drain_wait(input int base, input int exp, input string tag);
        int t = 0;
        while ((out_valid || !in_ready) && t < 200) begin @(posedge clk); #2; t++; end
        repeat (2) @(posedge clk);
        #2;
        chk(cap_n - base, exp, {tag, " word count"});
    endtask

    task automatic chk_slot(input int idx, input int s, input bit vld, input int op,
                            input string tag);
        word_t w;
        w = word_t'(cap[idx]);
        chk(int'(w[s].vld), int'(vld), $sformatf("%s w%0d s%0d vld", tag, idx, s));
        if (vld) chk(int'(w[s].op), op, $sformatf("%s w%0d s%0d op", tag, idx, s));
    endtask

    task automatic t_reset();
        chk(int'(in_ready), 1, "R1 in_ready after reset");
        chk(int'(out_valid), 0, "R1 out_valid after reset");
    endtask

    task automatic t_instr_mode();
        int b = cap_n;
        mode_bb = 1'b0;
        mem(1, 0, 0); mem(2, 1, 0);
        alu(3, 0, 0); alu(4, 0, 0); alu(5, 0, 0);
        alu(6, 0, 0); alu(7, 0, 0); alu(8, 1, 1);
        drain_wait(b, 4, "R3");
        chk_slot(b, 0, 1, 1, "R3");   chk_slot(b, 1, 0, 0, "R5");
        chk_slot(b, 2, 0, 0, "R5");   chk_slot(b, 3, 0, 0, "R5");
        chk_slot(b+1, 0, 1, 2, "R3");
        chk_slot(b+2, 0, 0, 0, "R5"); chk_slot(b+2, 1, 1, 3, "R3");
        chk_slot(b+2, 3, 1, 5, "R3");
        chk_slot(b+3, 1, 1, 6, "R3"); chk_slot(b+3, 3, 1, 8, "R3");
        chk(int'(cap_last[b]), 0, "R10 last w0");
        chk(int'(cap_last[b+1]), 1, "R10 last w1");
        chk(int'(cap_last[b+3]), 1, "R10 last w3");
    endtask

    task automatic t_block_mode();
        int b = cap_n;
        mode_bb = 1'b1;
        mem(1, 0, 0); mem(2, 1, 0);
        alu(3, 0, 0); alu(4, 0, 0); alu(5, 0, 0);
        alu(6, 0, 0); alu(7, 0, 0); alu(8, 1, 1);
        drain_wait(b, 2, "R4");
        chk_slot(b, 0, 1, 1, "R4");   chk_slot(b, 1, 1, 3, "R2");
        chk_slot(b, 2, 1, 4, "R2");   chk_slot(b, 3, 1, 5, "R2");
        chk_slot(b+1, 0, 1, 2, "R4"); chk_slot(b+1, 1, 1, 6, "R2");
        chk_slot(b+1, 3, 1, 8, "R2");
        chk(int'(cap_last[b]), 0, "R10 last w0");
        chk(int'(cap_last[b+1]), 1, "R10 last w1");
    endtask

    task automatic t_writes();
        int b = cap_n;
        word_t w;
        mode_bb = 1'b1;
        send(0, 10, 1, 5, 0, 0, 0, 0, 1, 0);
        send(0, 11, 1, 6, 0, 0, 0, 0, 1, 0);
        send(0, 12, 1, 5, 0, 0, 0, 0, 1, 1);
        drain_wait(b, 1, "R6");
        w = word_t'(cap[b]);
        chk(int'(w[1].dst_en), 0, "R6 overwritten write dropped");
        chk(int'(w[2].dst_en), 1, "R6 other reg kept");
        chk(int'(w[3].dst_en), 1, "R6 last write kept");
        chk(int'(w[3].dst), 5, "R6 last write reg");
        b = cap_n;
        mode_bb = 1'b0;
        send(0, 20, 1, 5, 0, 0, 0, 0, 1, 0);
        send(0, 21, 1, 5, 0, 0, 0, 0, 1, 1);
        drain_wait(b, 2, "R6 units");
        w = word_t'(cap[b]);
        chk(int'(w[1].dst_en), 1, "R6 write in earlier unit kept");
    endtask

    task automatic t_refs();
        int b = cap_n;
        word_t w;
        mode_bb = 1'b1;
        send(1, 30, 1, 1, 0, 0, 0, 0, 0, 0);
        send(0, 31, 0, 0, 1, 0, 0, 7, 0, 0);
        send(0, 32, 0, 0, 1, 1, 0, 0, 1, 1);
        drain_wait(b, 1, "R7");
        w = word_t'(cap[b]);
        chk(int'(w[1].src[0].loc), 1, "R7 local flag kept");
        chk(int'(w[1].src[0].val), 0, "R7 ref to mem slot w0");
        chk(int'(w[1].src[1].loc), 0, "R7 reg flag");
        chk(int'(w[1].src[1].val), 7, "R7 reg passes");
        chk(int'(w[2].src[0].val), 1, "R7 ref to w0 s1");
        b = cap_n;
        mem(40, 0, 0); mem(41, 0, 0);
        send(0, 42, 0, 0, 1, 1, 0, 0, 0, 0);
        alu(43, 1, 1);
        drain_wait(b, 2, "R8");
        chk_slot(b, 0, 1, 40, "R8");   chk_slot(b, 1, 0, 0, "R8 skipped");
        chk_slot(b+1, 0, 1, 41, "R8"); chk_slot(b+1, 1, 1, 42, "R8 moved");
        chk_slot(b+1, 2, 1, 43, "R8 follow"); chk_slot(b+1, 3, 0, 0, "R5");
        w = word_t'(cap[b+1]);
        chk(int'(w[1].src[0].val), 4, "R8 ref to w1 s0");
    endtask

    task automatic t_backpressure();
        int b = cap_n;
        logic [WB-1:0] held;
        mode_bb = 1'b1;
        out_ready = 1'b0;
        mem(50, 1, 1);
        @(negedge clk);
        chk(int'(out_valid), 1, "R9 word pending");
        chk(int'(in_ready), 0, "R9 input blocked");
        held = out_word;
        repeat (3) @(negedge clk);
        chk(int'(out_word == held), 1, "R9 word held");
        chk(int'(out_valid), 1, "R9 still valid");
        chk(int'(out_last), 1, "R10 single word last");
        chk(cap_n - b, 0, "R9 nothing taken");
        @(posedge clk); #2;
        out_ready = 1'b1;
        drain_wait(b, 1, "R9");
        chk_slot(b, 0, 1, 50, "R9");
        chk(int'(in_ready), 1, "R9 input reopens");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        @(posedge clk); #2;
        t_instr_mode();
        t_block_mode();
        t_writes();
        t_refs();
        t_backpressure();
        finish_run();
    end
endmodule